// File: doc/BRIEF.md
# Digit-Serial Gaussian Normal Basis Multiplier

This block multiplies two elements of the binary field GF(2^163). Both operands and the product are coded in a Gaussian normal basis of type 4. Bit i of every field vector is the coefficient of beta^(2^i). In this coding, squaring an element is a one-place cyclic rotation. The all-ones vector is the multiplicative identity and the all-zeros vector is the additive identity.

A caller presents two operands and pulses `start`. The block captures both operands and then works out the product one digit at a time. A digit is 55 consecutive coefficients, so a full product takes ceil(163/55) = 3 working cycles. It then writes the product to its output register and pulses `done` for one cycle.

Every coefficient comes from one base equation: an XOR of AND terms whose index pairs are fixed at elaboration from p = 4*163+1 = 653 and a unit of order 4 modulo p. Each next coefficient reuses that equation with every index moved up by one place, modulo 163. The field size, basis type and digit width are parameters. Setting the digit width equal to the field size gives a single-cycle parallel multiplier.

Top module: `gnb_mul_ds`

## Requirements
- R1: While `rst_n` is low at a clock edge, `c_out` becomes all zeros and `busy` and `done` become 0.
- R2: A `start` sampled high while `busy` is low captures `a_in` and `b_in` on that edge, and `busy` reads 1 from that edge on.
- R3: `done` is high for exactly one cycle. It rises on the third rising edge after the edge that accepted `start`, and `busy` is low whenever `done` is high.
- R4: Multiplying any operand by the all-ones vector returns that operand unchanged.
- R5: Multiplying any operand by the all-zeros vector, in either operand position, returns all zeros.
- R6: The product is commutative: swapping the two operands gives the same product.
- R7: A product of an operand with itself equals that operand rotated up one place: result bit i equals operand bit (i-1) mod 163.
- R8: The product distributes over bitwise XOR: A*(B xor C) = A*B xor A*C.
- R9: Index shifting is consistent: the square (one-place rotation) of A*B equals the product of the squares of A and B.
- R10: A `start` sampled while `busy` is high is ignored. The running product is still that of the operands captured at acceptance, and no extra run follows.
- R11: `c_out` changes only on the edge that raises `done`, and holds its value between completions whatever the inputs do.
- R12: The product is associative: (A*B)*C = A*(B*C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a product; taken only when idle |
| a_in | input | 163 | First operand, normal-basis coefficients |
| b_in | input | 163 | Second operand, normal-basis coefficients |
| c_out | output | 163 | Last completed product |
| busy | output | 1 | A product is in progress |
| done | output | 1 | One-cycle pulse when `c_out` has been updated |

## Verification
The embedded properties assume reset is held low for at least two edges before the first request, so that the result register and the latency counter start from known values. They assume nothing about `start`: it may stay high across a whole run. The operands matter only in the accepting cycle.

The stimulus drives every input on the falling edge and releases reset only after several cycles. It deliberately holds `start` high while a run is in progress, and it changes the operands while the block is idle. This exercises the ignore rule and the hold rule inside those assumptions.

Products are judged only through field identities: the unit, zero, rotation-as-squaring, commutativity, distributivity and associativity. Each side of an identity is computed on the block itself, so no copy of the index network exists in the bench.

// File: rtl/gnb_mul_pkg.sv
// Package gnb_mul_pkg
// Shared state type and elaboration-time integer helpers for the Gaussian
// normal basis multiplier. Assumes all arguments are small positive integers
// whose products fit in 32 bits (p below about 46000).
package gnb_mul_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gnb_state_e;

    // Ceiling of a/b for positive operands.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // base^ex mod modp by repeated multiplication.
    function automatic int pow_mod(input int base, input int ex, input int modp);
        int r;
        int bb;
        r  = 1;
        bb = base % modp;
        for (int i = 0; i < ex; i++) begin
            r = (r * bb) % modp;
        end
        return r;
    endfunction

    // Multiplicative order of x modulo modp, 0 if none found.
    function automatic int order_of(input int x, input int modp);
        int r;
        r = x % modp;
        for (int k = 1; k < modp; k++) begin
            if (r == 1) begin
                return k;
            end
            r = (r * x) % modp;
        end
        return 0;
    endfunction

    // Smallest-generator search for a unit of exact order t modulo modp.
    function automatic int find_unit(input int t, input int modp);
        int u;
        for (int g = 2; g < modp; g++) begin
            u = pow_mod(g, (modp - 1) / t, modp);
            if (order_of(u, modp) == t) begin
                return u;
            end
        end
        return 1;
    endfunction

endpackage

// File: rtl/gnb_coef.sv
// Module gnb_coef
// Computes one product coefficient of a Gaussian normal basis multiply: the
// XOR over k = 1..p-2 of a[F(k+1)+SH] & b[F(p-k)+SH], indices mod M.
// Assumes FT packs the index map F(1..p-1), IW bits per entry, and that the
// basis type is even so the self-paired terms cancel.
module gnb_coef #(
    parameter int M  = 163,
    parameter int P  = 653,
    parameter int IW = 8,
    parameter int SH = 0,
    parameter logic [P*IW-1:0] FT = '0
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic         c
);

    // Sum of the p-2 AND terms of the base equation shifted by SH places.
    always_comb begin
        logic            sum_v;
        logic [IW-1:0]   ia;
        logic [IW-1:0]   ib;
        sum_v = 1'b0;
        for (int k = 1; k <= P - 2; k++) begin
            ia    = IW'((int'(FT[(k+1)*IW +: IW]) + SH) % M);
            ib    = IW'((int'(FT[(P-k)*IW +: IW]) + SH) % M);
            sum_v = sum_v ^ (a[ia] & b[ib]);
        end
        c = sum_v;
    end

endmodule

// File: rtl/gnb_digit.sv
// Module gnb_digit
// Produces D consecutive product coefficients c0..c(D-1) of the two operands
// it is given. The caller rotates the operands to select the digit position.
// Builds the index map F at elaboration: F(2^i * u^j mod p) = i.
// Assumes p = T*M+1 is prime, T is even and a type-T normal basis exists.
module gnb_digit #(
    parameter int M = 163,
    parameter int T = 4,
    parameter int D = 55
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [D-1:0] digit
);

    localparam int P  = T * M + 1;
    localparam int IW = $clog2(M);
    localparam int U  = gnb_mul_pkg::find_unit(T, P);

    // Map each nonzero residue of p to the basis index of its coset.
    function automatic logic [P*IW-1:0] build_ftab();
        logic [P*IW-1:0] t;
        int w;
        int n;
        t = '0;
        w = 1;
        for (int j = 0; j < T; j++) begin
            n = w;
            for (int i = 0; i < M; i++) begin
                t[n*IW +: IW] = IW'(i);
                n = (2 * n) % P;
            end
            w = (w * U) % P;
        end
        return t;
    endfunction

    localparam logic [P*IW-1:0] FTAB = build_ftab();

    // One coefficient engine per digit position.
    for (genvar j = 0; j < D; j++) begin : g_coef
        gnb_coef #(
            .M (M),
            .P (P),
            .IW(IW),
            .SH(j),
            .FT(FTAB)
        ) u_coef (
            .a(a),
            .b(b),
            .c(digit[j])
        );
    end

endmodule

// File: rtl/gnb_opreg.sv
// Module gnb_opreg
// Operand register that loads a field element and, on each step, rotates it
// down by D places, so that bit i then holds the old bit (i+D) mod M.
// Assumes D <= M. Load has priority over shift.
module gnb_opreg #(
    parameter int M = 163,
    parameter int D = 55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [M-1:0] din,
    output logic [M-1:0] q
);

    logic [M-1:0] rot;

    // Cyclic rotation by one digit.
    always_comb begin
        for (int i = 0; i < M; i++) begin
            rot[i] = q[(i + D) % M];
        end
    end

    // Capture on load, advance one digit on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= rot;
        end
    end

endmodule

// File: rtl/gnb_ctrl.sv
// Module gnb_ctrl
// Sequencer for the digit-serial multiply: accepts start only when idle,
// runs NDIG step cycles, flags the last step and registers a done pulse.
// Assumes NDIG >= 1.
module gnb_ctrl
    import gnb_mul_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);

    localparam int CW = (NDIG > 1) ? $clog2(NDIG) : 1;

    gnb_state_e    state;
    logic [CW-1:0] cnt;

    // Decode of the sequencer state.
    always_comb begin
        load = start && (state == ST_IDLE);
        step = (state == ST_RUN);
        last = step && (cnt == CW'(NDIG - 1));
        busy = (state == ST_RUN);
    end

    // State, digit counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                state <= ST_RUN;
                cnt   <= '0;
            end else if (last) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (step) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= CW'(NDIG - 1)));                                  // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (busy && !done));                     // R10

endmodule

// File: rtl/gnb_mul_ds.sv
// Module gnb_mul_ds
// Digit-serial multiplier over GF(2^M) in a type-T Gaussian normal basis.
// Bit i of each vector is the coefficient of beta^(2^i). Each step produces
// D coefficients from rotated operands and shifts them into an accumulator.
// After NDIG steps the product is written to c_out and done pulses once.
// Assumes D <= M, p = T*M+1 prime, T even, and synchronous active-low reset.
module gnb_mul_ds #(
    parameter int M = 163,
    parameter int T = 4,
    parameter int D = 55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    output logic [M-1:0] c_out,
    output logic         busy,
    output logic         done
);

    localparam int NDIG = gnb_mul_pkg::ceil_div(M, D);
    localparam int W    = NDIG * D;

    logic         load;
    logic         step;
    logic         last;
    logic [M-1:0] a_q;
    logic [M-1:0] b_q;
    logic [D-1:0] digit;
    logic [W-1:0] acc_nxt;
    logic [M-1:0] c_q;

    gnb_ctrl #(.NDIG(NDIG)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .step (step),
        .last (last),
        .busy (busy),
        .done (done)
    );

    gnb_opreg #(.M(M), .D(D)) u_opa (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .shift(step),
        .din  (a_in),
        .q    (a_q)
    );

    gnb_opreg #(.M(M), .D(D)) u_opb (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .shift(step),
        .din  (b_in),
        .q    (b_q)
    );

    gnb_digit #(.M(M), .T(T), .D(D)) u_digit (
        .a    (a_q),
        .b    (b_q),
        .digit(digit)
    );

    if (NDIG > 1) begin : g_serial
        logic [W-D-1:0] acc_q;

        // New digit enters at the top; earlier digits move down.
        always_comb begin
            acc_nxt = {digit, acc_q};
        end

        // Accumulator of the digits finished so far.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= acc_nxt[W-1:D];
            end
        end
    end else begin : g_parallel
        // Whole product in one digit.
        always_comb begin
            acc_nxt = digit;
        end
    end

    // Result register, written only on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else if (last) begin
            c_q <= acc_nxt[M-1:0];
        end
    end

    assign c_out = c_q;

    // Observation counter of busy cycles since the last accepted start.
    logic [15:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (load) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 16'd1;
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == 16'(NDIG)));                                  // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                   // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(c_out));                                         // R11
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                        // R2

endmodule

// File: tb/sim_gnb_mul_ds.sv
// Bench for gnb_mul_ds: sweeps unit vectors and random operands through
// field identities whose two sides are both computed on the block.
module sim_gnb_mul_ds;

    localparam int M = 163;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [M-1:0] a_in;
    logic [M-1:0] b_in;
    logic [M-1:0] c_out;
    logic         busy;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gnb_mul_ds #(.M(M), .T(4), .D(55)) u0 (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .a_in (a_in),
        .b_in (b_in),
        .c_out(c_out),
        .busy (busy),
        .done (done)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [M-1:0] act, input logic [M-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [M-1:0] sq(input logic [M-1:0] x);
        return {x[M-2:0], x[M-1]};
    endfunction

    function automatic logic [M-1:0] rnd();
        logic [M-1:0] r;
        r = '0;
        for (int k = 0; k < 6; k++) begin
            r = {r[M-33:0], 32'($urandom)};
        end
        return r;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One product with latency (R2, R3) and hold (R11) checks.
    task automatic mul(input logic [M-1:0] a, input logic [M-1:0] b,
                       output logic [M-1:0] c);
        int cyc;
        @(negedge clk);
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", M'(busy), M'(1));
        cyc = 0;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 3, "R3 done latency", M'(cyc), M'(3));
        c = c_out;
        @(negedge clk);
        check(done == 1'b0, "R3 done single cycle", M'(done), M'(0));
        check(c_out == c, "R11 result held", c_out, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        logic [M-1:0] ones;
        logic [M-1:0] x;
        logic [M-1:0] y;
        logic [M-1:0] z;
        logic [M-1:0] r1;
        logic [M-1:0] r2;
        logic [M-1:0] r3;
        logic [M-1:0] r4;
        ones  = '1;
        rst_n = 1'b0;
        start = 1'b0;
        a_in  = '0;
        b_in  = '0;
        repeat (4) @(negedge clk);
        check(c_out == '0, "R1 reset c_out", c_out, '0);
        check(busy == 1'b0, "R1 reset busy", M'(busy), '0);
        check(done == 1'b0, "R1 reset done", M'(done), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", M'({busy, done}), '0);

        // R4, R7: sweep over every single-coefficient element.
        for (int i = 0; i < M; i++) begin
            x = '0;
            x[i] = 1'b1;
            mul(x, ones, r1);
            check(r1 == x, "R4 unit sweep", r1, x);
            mul(x, x, r2);
            check(r2 == sq(x), "R7 square sweep", r2, sq(x));
        end

        // R4, R5, R7 on random operands.
        for (int i = 0; i < 10; i++) begin
            x = rnd();
            mul(ones, x, r1);
            check(r1 == x, "R4 unit random", r1, x);
            mul(x, '0, r2);
            check(r2 == '0, "R5 zero right", r2, '0);
            mul('0, x, r3);
            check(r3 == '0, "R5 zero left", r3, '0);
            mul(x, x, r4);
            check(r4 == sq(x), "R7 square random", r4, sq(x));
        end

        // R6 commutativity.
        for (int i = 0; i < 8; i++) begin
            x = rnd();
            y = rnd();
            mul(x, y, r1);
            mul(y, x, r2);
            check(r1 == r2, "R6 commutative", r2, r1);
        end

        // R8 distributivity.
        for (int i = 0; i < 6; i++) begin
            x = rnd();
            y = rnd();
            z = rnd();
            mul(x, y ^ z, r1);
            mul(x, y, r2);
            mul(x, z, r3);
            check(r1 == (r2 ^ r3), "R8 distributive", r1, r2 ^ r3);
        end

        // R9 squaring commutes with the product.
        for (int i = 0; i < 6; i++) begin
            x = rnd();
            y = rnd();
            mul(x, y, r1);
            mul(sq(x), sq(y), r2);
            check(r2 == sq(r1), "R9 square of product", r2, sq(r1));
        end

        // R12 associativity.
        for (int i = 0; i < 6; i++) begin
            x = rnd();
            y = rnd();
            z = rnd();
            mul(x, y, r1);
            mul(r1, z, r2);
            mul(y, z, r3);
            mul(x, r3, r4);
            check(r2 == r4, "R12 associative", r4, r2);
        end

        // R10: start held high during a run is ignored.
        x = rnd();
        y = rnd();
        mul(x, y, r1);
        @(negedge clk);
        a_in  = x;
        b_in  = y;
        start = 1'b1;
        @(negedge clk);
        a_in = rnd();
        b_in = rnd();
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(c_out == r1, "R10 operands kept", c_out, r1);
        @(negedge clk);
        check(busy == 1'b0, "R10 no queued run", M'(busy), '0);
        repeat (4) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R10 stays idle", M'({busy, done}), '0);

        // R11: idle input changes leave c_out alone.
        a_in = rnd();
        b_in = rnd();
        repeat (5) @(negedge clk);
        check(c_out == r1, "R11 hold while idle", c_out, r1);

        summary();
        $finish;
    end

endmodule